// File: doc/BRIEF.md
# Character Blink Timer

This block produces the blink gate for a character display. It counts rising edges of the vertical sync input to measure a blink period of either 32 or 64 fields. Inside each period it shows characters for the first quarter, half or three quarters of the fields and hides them for the rest. Only characters whose own blink attribute is set are affected. A hidden blinking character is drawn in its background colour. Every other character passes with its foreground colour unchanged.

Pixels arrive on a valid/ready stream carrying a foreground colour, a background colour and the blink attribute. They leave on a valid/ready stream carrying the resolved colour and a shown flag. A beat is accepted when `in_valid_i` and `in_ready_o` are both high. The output register holds one beat. `in_ready_o` is high while that register is empty or is being drained in the same cycle (`out_ready_i` high). While `out_valid_o` is high and `out_ready_i` is low, the output beat stays frozen and no new beat is taken. The gate is sampled at the cycle a beat is accepted.

The control pins are plain levels: period select, duty code and global enable. The vertical sync input passes through a two-stage synchroniser (parameter `SYNC_STAGES`) and then an edge detector. The field index can therefore change up to four clock cycles after vsync rises.

Top module: `blink_gate_top`

## Requirements
- R1: After reset the field index is 0, `out_valid_o` is 0, and with duty code 00 `blink_visible_o` is 1.
- R2: The field index increments by exactly one for each rising edge of `vsync_i`. It does not change otherwise, except on wrap or restart.
- R3: The field index wraps from 31 to 0 when `period_long_i` is 0, and from 63 to 0 when it is 1.
- R4: Any change of `period_long_i` restarts the field index at 0.
- R5: Duty code 00 keeps `blink_visible_o` at 1. Codes 01, 10 and 11 make it 1 exactly while the field index is below one quarter, one half and three quarters of the period, respectively.
- R6: When `blink_en_i` is 0, `blink_visible_o` is 1 whatever the field index and duty code.
- R7: An accepted beat with blink attribute 1 leaves with its background colour and `out_shown_o` 0 if the gate was 0 at acceptance. Every other beat leaves with its foreground colour and `out_shown_o` 1.
- R8: `in_ready_o` equals `!out_valid_o || out_ready_i`. While `out_valid_o` is 1 and `out_ready_i` is 0, the output beat stays unchanged in the next cycle.
- R9: A vsync level held high for many cycles advances the field index only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vsync_i | input | 1 | Vertical sync level, asynchronous |
| period_long_i | input | 1 | 0: 32-field period, 1: 64-field period |
| duty_code_i | input | 2 | 00 off, 01 25 %, 10 50 %, 11 75 % visible |
| blink_en_i | input | 1 | Global blink enable |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat ready |
| in_fg_i | input | COLOR_W | Foreground colour |
| in_bg_i | input | COLOR_W | Background colour |
| in_blink_i | input | 1 | Character blink attribute |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Output beat ready |
| out_color_o | output | COLOR_W | Resolved colour |
| out_shown_o | output | 1 | 1 when the character is drawn |
| blink_visible_o | output | 1 | Current blink gate |
| field_idx_o | output | CNT_W | Field index inside the period |

## Verification
The gate is driven by runs of vsync pulses under each period and duty code, with thresholds of 8, 16 and 24 fields at a 32-field period and 16, 32 and 48 at a 64-field period. This separates a wrong threshold from a wrong wrap point. Period switches in mid-count show a restart as distinct from a carried-over index. A vsync held high for a long stretch shows edge counting as distinct from level counting. Pixels with and without the blink attribute, taken in both gate states, tell background substitution apart from foreground pass-through. A stalled output stream exposes any loss or overwrite of a held beat.

// File: rtl/blink_pkg.sv
package blink_pkg;
  typedef enum logic [1:0] {
    DUTY_OFF  = 2'b00,
    DUTY_QTR  = 2'b01,
    DUTY_HALF = 2'b10,
    DUTY_3QTR = 2'b11
  } duty_e;
endpackage

// File: rtl/blink_vsync_edge.sv
module blink_vsync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync_i,
  output logic rise_o
);
  logic synced;
  logic prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign synced = vsync_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else begin
          chain_q[0] <= vsync_i;
          for (int i = 1; i < SYNC_STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
      end
      assign synced = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;
  end

  assign rise_o = synced & ~prev_q;

  // R9
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/blink_field_counter.sv
module blink_field_counter #(
  parameter int SHORT_PERIOD = 32,
  parameter int LONG_PERIOD  = 64,
  parameter int CNT_W        = $clog2(LONG_PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             period_long_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_long_o
);
  localparam logic [CNT_W:0] SHORT_V = (CNT_W+1)'(SHORT_PERIOD);
  localparam logic [CNT_W:0] LONG_V  = (CNT_W+1)'(LONG_PERIOD);

  logic [CNT_W-1:0] cnt_q;
  logic             long_q;
  logic             sel_change;
  logic [CNT_W:0]   period_v;
  logic [CNT_W:0]   next_v;

  assign sel_change = (period_long_i != long_q);
  assign period_v   = long_q ? LONG_V : SHORT_V;
  assign next_v     = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else begin
      long_q <= period_long_i;
      if (sel_change)
        cnt_q <= '0;
      else if (rise_i)
        cnt_q <= (next_v == period_v) ? '0 : next_v[CNT_W-1:0];
    end
  end

  assign cnt_o         = cnt_q;
  assign active_long_o = long_q;

  // R3
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_o} < (active_long_o ? LONG_V : SHORT_V)));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_i && !sel_change) |=> $stable(cnt_o));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !sel_change) |=> (cnt_o == '0 || cnt_o == $past(cnt_o) + 1'b1));
  // R4
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |=> (cnt_o == '0));
endmodule

// File: rtl/blink_duty_gate.sv
module blink_duty_gate
  import blink_pkg::*;
#(
  parameter int SHORT_PERIOD = 32,
  parameter int LONG_PERIOD  = 64,
  parameter int CNT_W        = $clog2(LONG_PERIOD)
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             long_i,
  input  logic [1:0]       duty_i,
  input  logic             en_i,
  output logic             visible_o
);
  localparam logic [CNT_W:0] SHORT_V = (CNT_W+1)'(SHORT_PERIOD);
  localparam logic [CNT_W:0] LONG_V  = (CNT_W+1)'(LONG_PERIOD);

  logic [CNT_W:0] period_v;
  logic [CNT_W:0] thresh;
  duty_e          duty;

  assign period_v = long_i ? LONG_V : SHORT_V;
  assign duty     = duty_e'(duty_i);

  always_comb begin
    unique case (duty)
      DUTY_QTR:  thresh = period_v >> 2;
      DUTY_HALF: thresh = period_v >> 1;
      DUTY_3QTR: thresh = (period_v >> 1) + (period_v >> 2);
      default:   thresh = period_v;
    endcase
  end

  assign visible_o = !en_i || (duty == DUTY_OFF) || ({1'b0, cnt_i} < thresh);
endmodule

// File: rtl/blink_pixel_stage.sv
module blink_pixel_stage #(
  parameter int COLOR_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gate_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [COLOR_W-1:0] in_fg_i,
  input  logic [COLOR_W-1:0] in_bg_i,
  input  logic               in_blink_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [COLOR_W-1:0] out_color_o,
  output logic               out_shown_o
);
  logic               vld_q;
  logic [COLOR_W-1:0] color_q;
  logic               shown_q;
  logic               hide;

  assign in_ready_o = !vld_q || out_ready_i;
  assign hide       = in_blink_i && !gate_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      color_q <= '0;
      shown_q <= 1'b0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      if (in_valid_i) begin
        color_q <= hide ? in_bg_i : in_fg_i;
        shown_q <= !hide;
      end
    end
  end

  assign out_valid_o = vld_q;
  assign out_color_o = color_q;
  assign out_shown_o = shown_q;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_color_o) && $stable(out_shown_o)));
  // R7
  plain_char_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && !in_blink_i) |=> out_shown_o);
endmodule

// File: rtl/blink_gate_top.sv
module blink_gate_top #(
  parameter int SHORT_PERIOD = 32,
  parameter int LONG_PERIOD  = 64,
  parameter int SYNC_STAGES  = 2,
  parameter int COLOR_W      = 3,
  localparam int CNT_W       = $clog2(LONG_PERIOD)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync_i,
  input  logic               period_long_i,
  input  logic [1:0]         duty_code_i,
  input  logic               blink_en_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [COLOR_W-1:0] in_fg_i,
  input  logic [COLOR_W-1:0] in_bg_i,
  input  logic               in_blink_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [COLOR_W-1:0] out_color_o,
  output logic               out_shown_o,
  output logic               blink_visible_o,
  output logic [CNT_W-1:0]   field_idx_o
);
  logic             rise;
  logic [CNT_W-1:0] cnt;
  logic             active_long;
  logic             gate;

  blink_vsync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .rise_o(rise)
  );

  blink_field_counter #(
    .SHORT_PERIOD(SHORT_PERIOD), .LONG_PERIOD(LONG_PERIOD), .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .period_long_i(period_long_i),
    .cnt_o(cnt), .active_long_o(active_long)
  );

  blink_duty_gate #(
    .SHORT_PERIOD(SHORT_PERIOD), .LONG_PERIOD(LONG_PERIOD), .CNT_W(CNT_W)
  ) u_gate (
    .cnt_i(cnt), .long_i(active_long), .duty_i(duty_code_i),
    .en_i(blink_en_i), .visible_o(gate)
  );

  blink_pixel_stage #(.COLOR_W(COLOR_W)) u_pix (
    .clk(clk), .rst_n(rst_n), .gate_i(gate),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_fg_i(in_fg_i), .in_bg_i(in_bg_i), .in_blink_i(in_blink_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_color_o(out_color_o), .out_shown_o(out_shown_o)
  );

  assign blink_visible_o = gate;
  assign field_idx_o     = cnt;

  // R6
  gate_forced_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blink_en_i || duty_code_i == 2'b00) |-> blink_visible_o);
  // R8
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o == (!out_valid_o || out_ready_i));
endmodule

// File: tb/blink_gate_top_tb_top.sv
module blink_gate_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsync = 1'b0;
  logic       per_long = 1'b0;
  logic [1:0] duty = 2'b00;
  logic       en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] fg = '0, bg = '0;
  logic       attr = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [2:0] out_color;
  logic       out_shown;
  logic       vis;
  logic [5:0] idx;

  int checks = 0;
  int errors = 0;
  int m_idx = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  blink_gate_top dut_i (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .period_long_i(per_long),
    .duty_code_i(duty), .blink_en_i(en), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .in_fg_i(fg), .in_bg_i(bg), .in_blink_i(attr),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_color_o(out_color),
    .out_shown_o(out_shown), .blink_visible_o(vis), .field_idx_o(idx)
  );

  function automatic int period_of(bit lng);
    return lng ? 64 : 32;
  endfunction

  function automatic bit exp_vis(int i, bit lng, logic [1:0] d, bit e);
    int p = period_of(lng);
    if (!e || d == 2'b00) return 1'b1;
    return i < (p * int'(d)) / 4;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(int high_cycles);
    @(negedge clk) vsync = 1'b1;
    repeat (high_cycles) @(negedge clk);
    vsync = 1'b0;
    repeat (4) @(negedge clk);
    m_idx = (m_idx + 1 == period_of(per_long)) ? 0 : m_idx + 1;
  endtask

  task automatic set_period(bit v);
    @(negedge clk);
    if (v != per_long) m_idx = 0;
    per_long = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_state(string req);
    check({req, " idx"}, int'(idx), m_idx);
    check({req, " vis"}, int'(vis), int'(exp_vis(m_idx, per_long, duty, en)));
  endtask

  task automatic push(logic [2:0] f, logic [2:0] b, bit a);
    bit ev = exp_vis(m_idx, per_long, duty, en);
    bit hid = a && !ev;
    @(negedge clk);
    fg = f; bg = b; attr = a; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 valid", int'(out_valid), 1);
    check("R7 color", int'(out_color), int'(hid ? b : f));
    check("R7 shown", int'(out_shown), int'(!hid));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 idx", int'(idx), 0);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 vis", int'(vis), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idx after release", int'(idx), 0);

    // R5 quarter duty, 32 fields: threshold 8; R3 wrap at 32
    duty = 2'b01; en = 1'b1;
    for (int k = 0; k < 33; k++) begin
      pulse(2);
      check_state("R2 R5 R3 short");
    end
    // R7 hidden blink char and plain char at idx 1..: move into hidden window
    for (int k = 0; k < 10; k++) pulse(2);
    check_state("R5 hidden");
    push(3'd5, 3'd2, 1'b1);
    push(3'd6, 3'd1, 1'b0);

    // R6 global disable
    en = 1'b0;
    @(negedge clk);
    check_state("R6 disabled");
    push(3'd4, 3'd3, 1'b1);
    en = 1'b1;

    // R4 restart on period change, then R3 wrap at 64 with 75 % duty
    set_period(1'b1);
    check_state("R4 restart");
    duty = 2'b11;
    for (int k = 0; k < 65; k++) begin
      pulse(2);
      if (k % 8 == 0 || k >= 46) check_state("R3 R5 long");
    end

    // R9 held high vsync
    pulse(60);
    check_state("R9 held");

    // R8 back-pressure
    out_ready = 1'b0;
    push(3'd7, 3'd0, 1'b0);
    @(negedge clk) fg = 3'd1; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 in_ready low", int'(in_ready), 0);
    check("R8 held color", int'(out_color), 7);
    check("R8 held valid", int'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk) in_valid = 1'b0;
    check("R8 next beat", int'(out_color), 1);
    @(negedge clk);
    check("R8 drained", int'(out_valid), 0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int act = int'($urandom_range(0, 5));
      case (act)
        0, 1: begin
          pulse(int'($urandom_range(1, 3)));
          check_state("R2 rand");
        end
        2: begin
          set_period(1'($urandom_range(0, 1)));
          check_state("R4 rand");
        end
        3: begin
          @(negedge clk);
          duty = 2'($urandom_range(0, 3));
          en = ($urandom_range(0, 3) != 0);
          @(negedge clk);
          check_state("R5 R6 rand");
        end
        default: push(3'($urandom), 3'($urandom), 1'($urandom));
      endcase
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule